// File: doc/BRIEF.md
# Constrained LR/SC Loop Checker

This block observes the retire stream of one hart and judges every load-reserved / store-conditional sequence against the rules for a constrained loop, the only kind of LR/SC loop that is promised eventual success. A sequence opens when an LR retires and closes when the next SC retires. Between them the checker classifies every retired instruction. After an SC it keeps watching the retry code that runs until the same LR retires again. It also tracks the lowest and highest instruction addresses that the loop touches.

When the SC retires, the block raises a one-cycle verdict on the following clock. The verdict carries a pass flag and a three-bit violation code. The retire stage supplies the PC and the 32-bit instruction word. For a compressed instruction it supplies the expanded 32-bit form and sets a flag, so that the instruction occupies two bytes of address space. Branch outcome, branch target, and the effective address and size of memory operations come with each retire.

Top module: `lrsc_loop_checker`

## Requirements
- R1: An LR is opcode 0101111 with insn[31:27]=00010 and an SC is the same opcode with insn[31:27]=00011, both with funct3 010 (word) or 011 (doubleword). A sequence of permitted instructions closed by an SC with matching address and size, and a short enough span, gives verdict_pass=1 and code 0.
- R2: verdict_valid is high for exactly the one cycle after the clock edge that samples a retiring SC, and is low at all other times. verdict_pass is 1 only when code is 0. Both are 0 when no verdict is given.
- R3: Inside a sequence, only these major opcodes are permitted: 0110111, 0010111, 0010011, 0011011, 1101111, and 1100011, plus 0110011 and 0111011 when funct7 is not 0000001. Any other opcode gives code 1 at the SC. This covers load 0000011, store 0100011, fence 0001111, system/CSR/WFI 1110011, JALR 1100111 and multiply.
- R4: Inside a sequence, a JAL whose offset is negative (insn[31]=1) gives code 1. So does a branch that is taken to a target below its own PC. Forward jumps, taken forward branches and not-taken branches are permitted.
- R5: An instruction flagged as compressed carries its expanded word, is judged like that word, and occupies 2 bytes. Any other instruction occupies 4 bytes.
- R6: Retry code is every instruction retired after an SC until an LR retires at the same PC as the previous LR. Backward jumps and taken backward branches are permitted there.
- R7: A non-permitted instruction in the retry code gives code 2 at the SC that closes the re-entered sequence.
- R8: The span is measured from the lowest PC to the end of the highest instruction seen since the opening LR, including the retry code of a re-entered loop. If it exceeds 4*MAX_INSN bytes (64 by default), the SC gives code 3.
- R9: An SC whose mem_addr or mem_size (log2 of the byte count) differs from that of the latest LR gives code 4.
- R10: An SC with no open sequence gives code 5 and leaves the checker idle.
- R11: An LR retiring while a sequence is open restarts the sequence, clearing earlier violations and replacing the saved address and size.
- R12: The retry window is dropped after MAX_INSN retires without an LR, so a later LR at the same PC starts clean. Reset clears all tracking state.
- R13: When several violations apply, the code is chosen in the priority order 5, 1, 2, 3, 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | XLEN | PC of the retiring instruction |
| ret_insn | input | 32 | Instruction word (expanded form if compressed) |
| ret_compressed | input | 1 | Instruction was 16 bits in memory |
| ret_taken | input | 1 | Control transfer was taken |
| ret_target | input | XLEN | Target of the control transfer |
| mem_addr | input | XLEN | Effective address of a memory operation |
| mem_size | input | 2 | log2 of the access size in bytes |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_pass | output | 1 | Sequence qualifies as a constrained loop |
| verdict_code | output | 3 | Violation code, 0 on pass |

## Verification
The hardest situation to reach is a violation that only becomes visible one pass later. An illegal instruction in the retry code must be held across an SC verdict that itself passed, and then reported when the loop re-enters at the same LR. A span can also grow past the limit only through the retry path. The stimulus tables build full loop iterations for these cases: an SC, retry code holding a CSR access, WFI or a far forward jump, a backward jump to the exact LR address, then a second LR/SC pair. A directed test feeds enough retry instructions to expire the window and confirms that the same loop then passes.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPIMMW = 7'b0011011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPW    = 7'b0111011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_AMO    = 7'b0101111;
  localparam logic [6:0] FUNCT7_MUL = 7'b0000001;
  localparam logic [4:0] F5_LR      = 5'b00010;
  localparam logic [4:0] F5_SC      = 5'b00011;

  typedef enum logic [2:0] {
    VC_PASS        = 3'd0,
    VC_SEQ_CLASS   = 3'd1,
    VC_RETRY_CLASS = 3'd2,
    VC_SPAN        = 3'd3,
    VC_MISMATCH    = 3'd4,
    VC_NO_RES      = 3'd5
  } vcode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEQ   = 2'd1,
    ST_RETRY = 2'd2
  } lstate_t;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]      opcode,
  input  logic [6:0]      funct7,
  input  logic [2:0]      funct3,
  input  logic            taken,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] target,
  output logic            is_lr,
  output logic            is_sc,
  output logic            ok_seq,
  output logic            ok_retry
);
  logic size_ok, is_amo, base_ok, back_br, back_j;

  always_comb begin
    is_amo  = (opcode == OPC_AMO);
    size_ok = (funct3 == 3'b010) || (funct3 == 3'b011);
    is_lr   = is_amo && size_ok && (funct7[6:2] == F5_LR);
    is_sc   = is_amo && size_ok && (funct7[6:2] == F5_SC);
    back_br = (opcode == OPC_BRANCH) && taken && (target < pc);
    back_j  = (opcode == OPC_JAL) && funct7[6];
    case (opcode)
      OPC_LUI, OPC_AUIPC, OPC_OPIMM, OPC_OPIMMW,
      OPC_JAL, OPC_BRANCH:  base_ok = 1'b1;
      OPC_OP, OPC_OPW:      base_ok = (funct7 != FUNCT7_MUL);
      default:              base_ok = 1'b0;
    endcase
    ok_retry = base_ok;
    ok_seq   = base_ok && !back_br && !back_j;
  end
endmodule

// File: rtl/lrsc_span.sv
module lrsc_span #(
  parameter int XLEN        = 32,
  parameter int LIMIT_BYTES = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            upd,
  input  logic [XLEN-1:0] pc,
  input  logic            is_c,
  output logic            over
);
  logic [XLEN-1:0] lo_q, hi_q, lo_n, hi_n, end_pc;

  always_comb begin
    end_pc = pc + (is_c ? XLEN'(2) : XLEN'(4));
    if (start) begin
      lo_n = pc;
      hi_n = end_pc;
    end else begin
      lo_n = (pc < lo_q) ? pc : lo_q;
      hi_n = (end_pc > hi_q) ? end_pc : hi_q;
    end
    over = (hi_n - lo_n) > XLEN'(LIMIT_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (start || upd) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/lrsc_loop_checker.sv
module lrsc_loop_checker
  import lrsc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MAX_INSN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ret_valid,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [31:0]     ret_insn,
  input  logic            ret_compressed,
  input  logic            ret_taken,
  input  logic [XLEN-1:0] ret_target,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [1:0]      mem_size,
  output logic            verdict_valid,
  output logic            verdict_pass,
  output logic [2:0]      verdict_code
);
  localparam int LIMIT_BYTES = 4 * MAX_INSN;
  localparam int CW          = $clog2(MAX_INSN + 1);

  lstate_t         state_q;
  logic [XLEN-1:0] lr_addr_q, lr_pc_q;
  logic [1:0]      lr_size_q;
  logic            seq_bad_q, retry_bad_q;
  logic [CW-1:0]   rcnt_q;
  vcode_t          code_q, code_n;

  logic is_lr, is_sc, ok_seq, ok_retry;
  logic cont, span_start, span_upd, span_over, mismatch;
  wire  unused_bits = ^{ret_insn[24:15], ret_insn[11:7]};

  lrsc_decode #(.XLEN(XLEN)) u_dec (
    .opcode(ret_insn[6:0]), .funct7(ret_insn[31:25]), .funct3(ret_insn[14:12]),
    .taken(ret_taken), .pc(ret_pc), .target(ret_target),
    .is_lr(is_lr), .is_sc(is_sc), .ok_seq(ok_seq), .ok_retry(ok_retry)
  );

  always_comb begin
    cont       = (state_q == ST_RETRY) && (ret_pc == lr_pc_q);
    span_start = ret_valid && is_lr && !cont;
    span_upd   = ret_valid && (state_q != ST_IDLE) && !span_start;
    mismatch   = (mem_addr != lr_addr_q) || (mem_size != lr_size_q);
  end

  lrsc_span #(.XLEN(XLEN), .LIMIT_BYTES(LIMIT_BYTES)) u_span (
    .clk(clk), .rst(rst), .start(span_start), .upd(span_upd),
    .pc(ret_pc), .is_c(ret_compressed), .over(span_over)
  );

  always_comb begin
    if (state_q != ST_SEQ)  code_n = VC_NO_RES;
    else if (seq_bad_q)     code_n = VC_SEQ_CLASS;
    else if (retry_bad_q)   code_n = VC_RETRY_CLASS;
    else if (span_over)     code_n = VC_SPAN;
    else if (mismatch)      code_n = VC_MISMATCH;
    else                    code_n = VC_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      lr_addr_q     <= '0;
      lr_pc_q       <= '0;
      lr_size_q     <= '0;
      seq_bad_q     <= 1'b0;
      retry_bad_q   <= 1'b0;
      rcnt_q        <= '0;
      code_q        <= VC_PASS;
      verdict_valid <= 1'b0;
      verdict_pass  <= 1'b0;
    end else begin
      verdict_valid <= 1'b0;
      verdict_pass  <= 1'b0;
      code_q        <= VC_PASS;
      if (ret_valid) begin
        if (is_lr) begin
          state_q     <= ST_SEQ;
          lr_addr_q   <= mem_addr;
          lr_size_q   <= mem_size;
          lr_pc_q     <= ret_pc;
          seq_bad_q   <= 1'b0;
          retry_bad_q <= cont ? retry_bad_q : 1'b0;
        end else if (is_sc) begin
          verdict_valid <= 1'b1;
          verdict_pass  <= (code_n == VC_PASS);
          code_q        <= code_n;
          state_q       <= (state_q == ST_SEQ) ? ST_RETRY : ST_IDLE;
          seq_bad_q     <= 1'b0;
          retry_bad_q   <= 1'b0;
          rcnt_q        <= '0;
        end else if (state_q == ST_SEQ) begin
          if (!ok_seq) seq_bad_q <= 1'b1;
        end else if (state_q == ST_RETRY) begin
          if (rcnt_q == CW'(MAX_INSN - 1)) begin
            state_q     <= ST_IDLE;
            retry_bad_q <= 1'b0;
            rcnt_q      <= '0;
          end else begin
            rcnt_q <= rcnt_q + 1'b1;
            if (!ok_retry) retry_bad_q <= 1'b1;
          end
        end
      end
    end
  end

  assign verdict_code = code_q;
endmodule

// File: rtl/lrsc_loop_checker_sva.sv
module lrsc_loop_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       ret_valid,
  input logic [6:0] op,
  input logic [4:0] f5,
  input logic       verdict_valid,
  input logic       verdict_pass,
  input logic [2:0] verdict_code
);
  AST_VERDICT_AFTER_SC: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> ($past(ret_valid) && $past(op) == 7'b0101111 && $past(f5) == 5'b00011)); // R2
  AST_PASS_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    verdict_pass |-> (verdict_valid && verdict_code == 3'd0)); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !verdict_valid |-> (!verdict_pass && verdict_code == 3'd0)); // R2
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> (verdict_code <= 3'd5)); // R13
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !verdict_valid); // R12
endmodule

bind lrsc_loop_checker lrsc_loop_checker_sva u_sva (
  .clk(clk), .rst(rst), .ret_valid(ret_valid),
  .op(ret_insn[6:0]), .f5(ret_insn[31:27]),
  .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
  .verdict_code(verdict_code)
);

// File: tb/lrsc_loop_checker_test.sv
`timescale 1ns/1ps
module lrsc_loop_checker_test;
  localparam logic [31:0] LRW  = 32'h1002A3AF;
  localparam logic [31:0] LRD  = 32'h1002B3AF;
  localparam logic [31:0] SCW  = 32'h1872A3AF;
  localparam logic [31:0] ADDI = 32'h00100393;
  localparam logic [31:0] BNE  = 32'h00039463;
  localparam logic [31:0] JBK  = 32'hFF1FF06F;
  localparam logic [31:0] JFW  = 32'h0080006F;
  localparam logic [31:0] LW   = 32'h0002A303;
  localparam logic [31:0] CSRR = 32'hF1402373;
  localparam logic [31:0] WFI  = 32'h10500073;
  localparam logic [31:0] FNC  = 32'h0FF0000F;
  localparam logic [31:0] JALR = 32'h00008067;
  localparam logic [31:0] MUL  = 32'h027383B3;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] insn;
    logic        c;
    logic        tk;
    logic [31:0] tgt;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        ev;
    logic [2:0]  ec;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 58;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h100, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd1},
    '{32'h104, BNE,  1'b0, 1'b0, 32'h10C, 32'h0,    2'd0, 1'b0, 3'd0, 4'd1},
    '{32'h108, ADDI, 1'b0, 1'b0, 32'h0,   32'h0,    2'd0, 1'b0, 3'd0, 4'd1},
    '{32'h10C, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd0, 4'd1},  // R1
    '{32'h110, JBK,  1'b0, 1'b1, 32'h100, 32'h0,    2'd0, 1'b0, 3'd0, 4'd6},
    '{32'h100, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd6},
    '{32'h104, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd0, 4'd6},  // R6
    '{32'h200, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd3},
    '{32'h204, LW,   1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd3},
    '{32'h208, SCW,  1'b0, 1'b0, 32'h0,   32'h2008, 2'd2, 1'b1, 3'd1, 4'd13}, // R13 / R3
    '{32'h20C, CSRR, 1'b0, 1'b0, 32'h0,   32'h0,    2'd0, 1'b0, 3'd0, 4'd7},
    '{32'h210, JBK,  1'b0, 1'b1, 32'h200, 32'h0,    2'd0, 1'b0, 3'd0, 4'd7},
    '{32'h200, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd7},
    '{32'h204, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd2, 4'd7},  // R7
    '{32'h300, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd8},
    '{32'h304, JFW,  1'b0, 1'b1, 32'h344, 32'h0,    2'd0, 1'b0, 3'd0, 4'd8},
    '{32'h344, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd3, 4'd8},  // R8
    '{32'h400, LRW,  1'b0, 1'b0, 32'h0,   32'h3000, 2'd2, 1'b0, 3'd0, 4'd9},
    '{32'h404, SCW,  1'b0, 1'b0, 32'h0,   32'h3004, 2'd2, 1'b1, 3'd4, 4'd9},  // R9 address
    '{32'h500, LRD,  1'b0, 1'b0, 32'h0,   32'h3000, 2'd3, 1'b0, 3'd0, 4'd9},
    '{32'h504, SCW,  1'b0, 1'b0, 32'h0,   32'h3000, 2'd2, 1'b1, 3'd4, 4'd9},  // R9 size
    '{32'h508, SCW,  1'b0, 1'b0, 32'h0,   32'h3000, 2'd2, 1'b1, 3'd5, 4'd10}, // R10
    '{32'h600, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd4},
    '{32'h604, BNE,  1'b0, 1'b1, 32'h5F0, 32'h0,    2'd0, 1'b0, 3'd0, 4'd4},
    '{32'h5F0, ADDI, 1'b0, 1'b0, 32'h0,   32'h0,    2'd0, 1'b0, 3'd0, 4'd4},
    '{32'h5F4, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd1, 4'd4},  // R4 backward branch
    '{32'h700, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd4},
    '{32'h704, BNE,  1'b0, 1'b1, 32'h70C, 32'h0,    2'd0, 1'b0, 3'd0, 4'd4},
    '{32'h70C, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd0, 4'd4},  // R4 forward ok
    '{32'h800, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd5},
    '{32'h804, ADDI, 1'b1, 1'b0, 32'h0,   32'h0,    2'd0, 1'b0, 3'd0, 4'd5},
    '{32'h806, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd0, 4'd5},  // R5
    '{32'h900, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd11},
    '{32'h904, LW,   1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd11},
    '{32'h908, LRW,  1'b0, 1'b0, 32'h0,   32'h2100, 2'd2, 1'b0, 3'd0, 4'd11},
    '{32'h90C, SCW,  1'b0, 1'b0, 32'h0,   32'h2100, 2'd2, 1'b1, 3'd0, 4'd11}, // R11
    '{32'hA00, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd3},
    '{32'hA04, MUL,  1'b0, 1'b0, 32'h0,   32'h0,    2'd0, 1'b0, 3'd0, 4'd3},
    '{32'hA08, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd1, 4'd3},  // R3 multiply
    '{32'hA0C, WFI,  1'b0, 1'b0, 32'h0,   32'h0,    2'd0, 1'b0, 3'd0, 4'd7},
    '{32'hA10, JBK,  1'b0, 1'b1, 32'hA00, 32'h0,    2'd0, 1'b0, 3'd0, 4'd7},
    '{32'hA00, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd7},
    '{32'hA04, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd2, 4'd7},  // R7 WFI
    '{32'hB00, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd3},
    '{32'hB04, JALR, 1'b0, 1'b1, 32'hB08, 32'h0,    2'd0, 1'b0, 3'd0, 4'd3},
    '{32'hB08, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd1, 4'd3},  // R3 JALR
    '{32'hC00, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd3},
    '{32'hC04, FNC,  1'b0, 1'b0, 32'h0,   32'h0,    2'd0, 1'b0, 3'd0, 4'd3},
    '{32'hC08, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd1, 4'd3},  // R3 fence
    '{32'hD00, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd8},
    '{32'hD04, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd0, 4'd8},
    '{32'hD08, JFW,  1'b0, 1'b1, 32'hD48, 32'h0,    2'd0, 1'b0, 3'd0, 4'd8},
    '{32'hD48, JBK,  1'b0, 1'b1, 32'hD00, 32'h0,    2'd0, 1'b0, 3'd0, 4'd8},
    '{32'hD00, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd8},
    '{32'hD04, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd3, 4'd8},  // R8 via retry
    '{32'hF00, LRW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b0, 3'd0, 4'd4},
    '{32'hF04, JBK,  1'b0, 1'b1, 32'hEF0, 32'h0,    2'd0, 1'b0, 3'd0, 4'd4},
    '{32'hEF0, SCW,  1'b0, 1'b0, 32'h0,   32'h2000, 2'd2, 1'b1, 3'd1, 4'd4}   // R4 backward jump
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_pc = '0, ret_insn = '0, ret_target = '0, mem_addr = '0;
  logic        ret_compressed = 1'b0, ret_taken = 1'b0;
  logic [1:0]  mem_size = '0;
  logic        verdict_valid, verdict_pass;
  logic [2:0]  verdict_code;
  int          n_vec = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  lrsc_loop_checker uut (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_insn(ret_insn), .ret_compressed(ret_compressed), .ret_taken(ret_taken),
    .ret_target(ret_target), .mem_addr(mem_addr), .mem_size(mem_size),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
    .verdict_code(verdict_code)
  );

  task automatic check(input int req, input logic ev, input logic [2:0] ec);
    logic ep;
    ep = ev && (ec == 3'd0);
    n_vec++;
    if (verdict_valid !== ev || verdict_pass !== ep || verdict_code !== (ev ? ec : 3'd0)) begin
      n_bad++;
      $display("FAIL R%0d: got valid=%0b pass=%0b code=%0d, expected valid=%0b pass=%0b code=%0d",
               req, verdict_valid, verdict_pass, verdict_code, ev, ep, ev ? ec : 3'd0);
    end
  endtask

  task automatic retire(input logic [31:0] pc, input logic [31:0] insn, input logic c,
                        input logic tk, input logic [31:0] tgt, input logic [31:0] addr,
                        input logic [1:0] sz);
    ret_valid = 1'b1; ret_pc = pc; ret_insn = insn; ret_compressed = c;
    ret_taken = tk; ret_target = tgt; mem_addr = addr; mem_size = sz;
    @(posedge clk);
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(2, 1'b0, 3'd0);                       // R2 quiet in reset
    rst = 1'b0;
    @(negedge clk);
    check(2, 1'b0, 3'd0);                       // R2 quiet after reset

    for (int i = 0; i < NV; i++) begin
      retire(VECS[i].pc, VECS[i].insn, VECS[i].c, VECS[i].tk, VECS[i].tgt,
             VECS[i].addr, VECS[i].sz);
      check(int'(VECS[i].req), VECS[i].ev, VECS[i].ec);
    end

    // R2: pulse lasts one cycle
    @(negedge clk);
    check(2, 1'b0, 3'd0);

    // R12: retry window expires after MAX_INSN retires without an LR
    retire(32'h1000, LRW, 1'b0, 1'b0, 32'h0, 32'h2000, 2'd2);
    retire(32'h1004, SCW, 1'b0, 1'b0, 32'h0, 32'h2000, 2'd2);
    check(1, 1'b1, 3'd0);
    retire(32'h1008, LW, 1'b0, 1'b0, 32'h0, 32'h2000, 2'd2);
    for (int k = 0; k < 15; k++) retire(32'h100C, ADDI, 1'b0, 1'b0, 32'h0, 32'h0, 2'd0);
    retire(32'h1000, LRW, 1'b0, 1'b0, 32'h0, 32'h2000, 2'd2);
    retire(32'h1004, SCW, 1'b0, 1'b0, 32'h0, 32'h2000, 2'd2);
    check(12, 1'b1, 3'd0);                      // R12 window expired

    // R12: reset in the middle of a sequence clears it
    retire(32'h1100, LRW, 1'b0, 1'b0, 32'h0, 32'h2000, 2'd2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    retire(32'h1104, SCW, 1'b0, 1'b0, 32'h0, 32'h2000, 2'd2);
    check(12, 1'b1, 3'd5);                      // R12 / R10

    finish_run();
  end
endmodule